// File: doc/BRIEF.md
# DMA Channel Security Permission Checker

This block sits beside the instruction decoder of a multi-channel DMA engine. Each channel thread can issue event and peripheral instructions: wait for an event, send an event, wait for a peripheral request, and acknowledge a peripheral after a load or a store. When the issuing thread runs in the non-secure state, the block looks up a per-event or per-peripheral permission bit. If the bit allows it, the instruction goes ahead: the channel waits, an event pulse is raised, or an acknowledge pulse is sent. If the bit denies it, the instruction does nothing. The channel is then flagged as faulted, together with the kind of fault, and is parked in a faulting-completing state.

The block keeps a small state machine for each channel. A start strobe brings an idle channel into execution. Instructions are accepted only from an executing channel. A waiting channel resumes once the event or peripheral request it waits on arrives. A per-channel clear strobe removes the fault flags and returns a faulted channel to idle.

Top module: `dma_perm_guard`

## Requirements
- R1: After reset every channel reads idle (code 0), all fault vectors are zero and no event or acknowledge pulse is active.
- R2: An idle channel whose `chanStart` bit is high reads executing (code 1) one cycle later.
- R3: A permitted wait-for-event (`opKind` 1) moves the channel to waiting-event (code 2) on the next cycle. The channel returns to executing on the cycle after `evtIn` goes high at the stored index; inputs at other indices do not wake it.
- R4: A permitted send-event (`opKind` 2) produces a one-cycle pulse on `evtPulse` at bit `opIdx`, one cycle after issue. The channel stays executing.
- R5: A permitted wait-for-peripheral (`opKind` 3) moves the channel to waiting-peripheral (code 3). The channel returns to executing on the cycle after `perReq` goes high at the stored index.
- R6: A permitted load acknowledge (`opKind` 4) or store acknowledge (`opKind` 5) produces a one-cycle pulse at bit `opIdx` of `ldAckPulse` or `stAckPulse`, one cycle after issue.
- R7: A non-secure event instruction (`opKind` 1 or 2) whose bit in `evtNsMask` is 0 produces no wait and no pulse. It sets the channel's bit in `faultStatus` and in `faultEvtErr`, and the channel moves to faulting-completing (code 4).
- R8: A non-secure peripheral instruction (`opKind` 3, 4 or 5) whose bit in `perNsMask` is 0 produces no wait and no pulse. It sets the channel's bit in `faultStatus` and in `faultPerErr`, and the channel moves to faulting-completing.
- R9: A secure thread (`opNonSec` = 0) skips the mask lookup and is always allowed.
- R10: Fault bits stay set until the channel's `faultClr` bit is high. That strobe clears all three fault bits of the channel and moves a faulting channel back to idle. A new fault on the same channel in the same cycle wins over the clear.
- R11: An instruction aimed at a channel that is not executing, or one with `opKind` 0, 6 or 7, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Decoded instruction present this cycle |
| opKind | input | 3 | 1 wait-event, 2 send-event, 3 wait-peripheral, 4 load ack, 5 store ack |
| opIdx | input | 5 | Event or peripheral index |
| opChan | input | 3 | Issuing channel |
| opNonSec | input | 1 | Issuing thread is non-secure |
| evtNsMask | input | 32 | Per-event non-secure permission |
| perNsMask | input | 32 | Per-peripheral non-secure permission |
| evtIn | input | 32 | Event occurrence inputs |
| perReq | input | 32 | Peripheral request inputs |
| chanStart | input | 8 | Per-channel start strobe |
| faultClr | input | 8 | Per-channel fault clear strobe |
| chanState | output | 24 | Packed 3-bit state per channel, channel 0 in the low bits |
| evtPulse | output | 32 | Event raise pulses |
| ldAckPulse | output | 32 | Load acknowledge pulses |
| stAckPulse | output | 32 | Store acknowledge pulses |
| faultStatus | output | 8 | Per-channel fault flag |
| faultEvtErr | output | 8 | Per-channel event-error flag |
| faultPerErr | output | 8 | Per-channel peripheral-error flag |

## Verification
The bench builds the block with its default parameters: 8 channels, 32 events and 32 peripherals. With these values it can reach both ends of the index range (0 and 31), and it can use four channels at once that sit in different states. A behavioural model predicts every output on every cycle. The stimulus covers the allowed path and the denied path for each instruction kind, a secure bypass against a closed mask, wake-ups at a wrong index, instructions sent to channels that are not executing, and a fault clear on one channel while another channel stays faulted.

// File: rtl/dmapg_pkg.sv
package dmapg_pkg;
  typedef enum logic [2:0] {
    CH_IDLE     = 3'd0,
    CH_EXEC     = 3'd1,
    CH_WAIT_EVT = 3'd2,
    CH_WAIT_PER = 3'd3,
    CH_FAULT    = 3'd4
  } chState_t;

  localparam logic [2:0] OP_WFE   = 3'd1;
  localparam logic [2:0] OP_SEV   = 3'd2;
  localparam logic [2:0] OP_WFP   = 3'd3;
  localparam logic [2:0] OP_LDACK = 3'd4;
  localparam logic [2:0] OP_STACK = 3'd5;

  // strobes from control to datapath for one accepted instruction
  typedef struct packed {
    logic evtFire;
    logic ldFire;
    logic stFire;
    logic evtErr;
    logic perErr;
  } guardStrobe_t;
endpackage

// File: rtl/dmapg_ctrl.sv
module dmapg_ctrl
  import dmapg_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_EVT = 32,
  parameter int NUM_PER = 32,
  parameter int CH_W    = 3,
  parameter int IDX_W   = 5,
  parameter int EVT_W   = 5,
  parameter int PER_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [2:0]          opKind,
  input  logic [IDX_W-1:0]    opIdx,
  input  logic [CH_W-1:0]     opChan,
  input  logic                opNonSec,
  input  logic                nsAllowed,
  input  logic [NUM_EVT-1:0]  evtIn,
  input  logic [NUM_PER-1:0]  perReq,
  input  logic [NUM_CH-1:0]   chanStart,
  input  logic [NUM_CH-1:0]   faultClr,
  output guardStrobe_t        strobe,
  output logic [3*NUM_CH-1:0] chanState
);
  chState_t         st   [NUM_CH];
  logic [IDX_W-1:0] wIdx [NUM_CH];

  logic opHit, permit, evtKind, kindOk;

  always_comb begin
    kindOk  = (opKind >= OP_WFE) && (opKind <= OP_STACK);
    opHit   = opValid && kindOk && (st[opChan] == CH_EXEC);
    permit  = !opNonSec || nsAllowed;
    evtKind = (opKind == OP_WFE) || (opKind == OP_SEV);
    strobe.evtFire = opHit && permit && (opKind == OP_SEV);
    strobe.ldFire  = opHit && permit && (opKind == OP_LDACK);
    strobe.stFire  = opHit && permit && (opKind == OP_STACK);
    strobe.evtErr  = opHit && !permit && evtKind;
    strobe.perErr  = opHit && !permit && !evtKind;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic mine;
    assign mine = opHit && (opChan == CH_W'(c));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        st[c]   <= CH_IDLE;
        wIdx[c] <= '0;
      end else if (mine) begin
        if (!permit) begin
          st[c] <= CH_FAULT;
        end else if (opKind == OP_WFE) begin
          st[c]   <= CH_WAIT_EVT;
          wIdx[c] <= opIdx;
        end else if (opKind == OP_WFP) begin
          st[c]   <= CH_WAIT_PER;
          wIdx[c] <= opIdx;
        end
      end else begin
        case (st[c])
          CH_IDLE:     if (chanStart[c]) st[c] <= CH_EXEC;
          CH_WAIT_EVT: if (evtIn[wIdx[c][EVT_W-1:0]]) st[c] <= CH_EXEC;
          CH_WAIT_PER: if (perReq[wIdx[c][PER_W-1:0]]) st[c] <= CH_EXEC;
          CH_FAULT:    if (faultClr[c]) st[c] <= CH_IDLE;
          default:     ;
        endcase
      end
    end

    assign chanState[3*c +: 3] = st[c];
  end
endmodule

// File: rtl/dmapg_dpath.sv
module dmapg_dpath
  import dmapg_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_EVT = 32,
  parameter int NUM_PER = 32,
  parameter int CH_W    = 3,
  parameter int IDX_W   = 5,
  parameter int EVT_W   = 5,
  parameter int PER_W   = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         opKind,
  input  logic [IDX_W-1:0]   opIdx,
  input  logic [CH_W-1:0]    opChan,
  input  logic [NUM_EVT-1:0] evtNsMask,
  input  logic [NUM_PER-1:0] perNsMask,
  input  logic [NUM_CH-1:0]  faultClr,
  input  guardStrobe_t       strobe,
  output logic               nsAllowed,
  output logic [NUM_EVT-1:0] evtPulse,
  output logic [NUM_PER-1:0] ldAckPulse,
  output logic [NUM_PER-1:0] stAckPulse,
  output logic [NUM_CH-1:0]  faultStatus,
  output logic [NUM_CH-1:0]  faultEvtErr,
  output logic [NUM_CH-1:0]  faultPerErr
);
  always_comb begin
    if ((opKind == OP_WFE) || (opKind == OP_SEV))
      nsAllowed = evtNsMask[opIdx[EVT_W-1:0]];
    else
      nsAllowed = perNsMask[opIdx[PER_W-1:0]];
  end

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rstN) evtPulse[e] <= 1'b0;
      else       evtPulse[e] <= strobe.evtFire && (opIdx == IDX_W'(e));
    end
  end

  for (genvar p = 0; p < NUM_PER; p++) begin : g_per
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ldAckPulse[p] <= 1'b0;
        stAckPulse[p] <= 1'b0;
      end else begin
        ldAckPulse[p] <= strobe.ldFire && (opIdx == IDX_W'(p));
        stAckPulse[p] <= strobe.stFire && (opIdx == IDX_W'(p));
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flt
    logic hit;
    assign hit = (strobe.evtErr || strobe.perErr) && (opChan == CH_W'(c));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        faultStatus[c] <= 1'b0;
        faultEvtErr[c] <= 1'b0;
        faultPerErr[c] <= 1'b0;
      end else if (hit) begin
        faultStatus[c] <= 1'b1;
        faultEvtErr[c] <= (faultEvtErr[c] && !faultClr[c]) || strobe.evtErr;
        faultPerErr[c] <= (faultPerErr[c] && !faultClr[c]) || strobe.perErr;
      end else if (faultClr[c]) begin
        faultStatus[c] <= 1'b0;
        faultEvtErr[c] <= 1'b0;
        faultPerErr[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_perm_guard.sv
module dma_perm_guard
  import dmapg_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_EVT = 32,
  parameter int NUM_PER = 32,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int EVT_W  = $clog2(NUM_EVT),
  localparam int PER_W  = $clog2(NUM_PER),
  localparam int IDX_W  = (EVT_W > PER_W) ? EVT_W : PER_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [2:0]          opKind,
  input  logic [IDX_W-1:0]    opIdx,
  input  logic [CH_W-1:0]     opChan,
  input  logic                opNonSec,
  input  logic [NUM_EVT-1:0]  evtNsMask,
  input  logic [NUM_PER-1:0]  perNsMask,
  input  logic [NUM_EVT-1:0]  evtIn,
  input  logic [NUM_PER-1:0]  perReq,
  input  logic [NUM_CH-1:0]   chanStart,
  input  logic [NUM_CH-1:0]   faultClr,
  output logic [3*NUM_CH-1:0] chanState,
  output logic [NUM_EVT-1:0]  evtPulse,
  output logic [NUM_PER-1:0]  ldAckPulse,
  output logic [NUM_PER-1:0]  stAckPulse,
  output logic [NUM_CH-1:0]   faultStatus,
  output logic [NUM_CH-1:0]   faultEvtErr,
  output logic [NUM_CH-1:0]   faultPerErr
);
  guardStrobe_t strobe;
  logic         nsAllowed;

  dmapg_ctrl #(
    .NUM_CH(NUM_CH), .NUM_EVT(NUM_EVT), .NUM_PER(NUM_PER),
    .CH_W(CH_W), .IDX_W(IDX_W), .EVT_W(EVT_W), .PER_W(PER_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .opIdx(opIdx), .opChan(opChan), .opNonSec(opNonSec),
    .nsAllowed(nsAllowed), .evtIn(evtIn), .perReq(perReq),
    .chanStart(chanStart), .faultClr(faultClr),
    .strobe(strobe), .chanState(chanState)
  );

  dmapg_dpath #(
    .NUM_CH(NUM_CH), .NUM_EVT(NUM_EVT), .NUM_PER(NUM_PER),
    .CH_W(CH_W), .IDX_W(IDX_W), .EVT_W(EVT_W), .PER_W(PER_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .opKind(opKind), .opIdx(opIdx),
    .opChan(opChan), .evtNsMask(evtNsMask), .perNsMask(perNsMask),
    .faultClr(faultClr), .strobe(strobe), .nsAllowed(nsAllowed),
    .evtPulse(evtPulse), .ldAckPulse(ldAckPulse), .stAckPulse(stAckPulse),
    .faultStatus(faultStatus), .faultEvtErr(faultEvtErr),
    .faultPerErr(faultPerErr)
  );
endmodule

// File: rtl/dma_perm_guard_chk.sv
module dma_perm_guard_chk #(
  parameter int NUM_CH  = 8,
  parameter int NUM_EVT = 32,
  parameter int NUM_PER = 32,
  parameter int CH_W    = 3,
  parameter int IDX_W   = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                opValid,
  input logic [2:0]          opKind,
  input logic [IDX_W-1:0]    opIdx,
  input logic [CH_W-1:0]     opChan,
  input logic                opNonSec,
  input logic [NUM_EVT-1:0]  evtNsMask,
  input logic [NUM_PER-1:0]  perNsMask,
  input logic [3*NUM_CH-1:0] chanState,
  input logic [NUM_EVT-1:0]  evtPulse,
  input logic [NUM_PER-1:0]  ldAckPulse,
  input logic [NUM_PER-1:0]  stAckPulse,
  input logic [NUM_CH-1:0]   faultStatus,
  input logic [NUM_CH-1:0]   faultEvtErr,
  input logic [NUM_CH-1:0]   faultPerErr
);
  logic       srcExec;
  logic       evtOp;
  logic       perOp;
  assign srcExec = opValid && (chanState[3*int'(opChan) +: 3] == 3'd1);
  assign evtOp   = (opKind == 3'd1) || (opKind == 3'd2);
  assign perOp   = (opKind >= 3'd3) && (opKind <= 3'd5);

  assert_evt_deny_R7: assert property (@(posedge clk) disable iff (!rstN)
    srcExec && opNonSec && evtOp && !evtNsMask[opIdx]
    |=> faultStatus[$past(opChan)] && faultEvtErr[$past(opChan)] && (evtPulse == '0));

  assert_per_deny_R8: assert property (@(posedge clk) disable iff (!rstN)
    srcExec && opNonSec && perOp && !perNsMask[opIdx]
    |=> faultStatus[$past(opChan)] && faultPerErr[$past(opChan)]
        && (ldAckPulse == '0) && (stAckPulse == '0));

  assert_sec_bypass_R9: assert property (@(posedge clk) disable iff (!rstN)
    srcExec && !opNonSec && (evtOp || perOp)
    |=> chanState[3*int'($past(opChan)) +: 3] != 3'd4);

  assert_sev_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |-> $onehot0(evtPulse) && $past(opValid && (opKind == 3'd2)));

  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ldAckPulse != '0) |-> $onehot0(ldAckPulse) && $past(opValid && (opKind == 3'd4)));

  assert_fault_type_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((faultEvtErr | faultPerErr) & ~faultStatus) == '0);
endmodule

bind dma_perm_guard dma_perm_guard_chk #(
  .NUM_CH(NUM_CH), .NUM_EVT(NUM_EVT), .NUM_PER(NUM_PER),
  .CH_W(CH_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
  .opIdx(opIdx), .opChan(opChan), .opNonSec(opNonSec),
  .evtNsMask(evtNsMask), .perNsMask(perNsMask), .chanState(chanState),
  .evtPulse(evtPulse), .ldAckPulse(ldAckPulse), .stAckPulse(stAckPulse),
  .faultStatus(faultStatus), .faultEvtErr(faultEvtErr),
  .faultPerErr(faultPerErr)
);

// File: tb/sim_dma_perm_guard.sv
`timescale 1ns/1ps
module sim_dma_perm_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opKind = 3'd0;
  logic [4:0]  opIdx = 5'd0;
  logic [2:0]  opChan = 3'd0;
  logic        opNonSec = 1'b0;
  logic [31:0] evtNsMask = 32'h0000_0280; // bits 7 and 9 open
  logic [31:0] perNsMask = 32'h8000_0404; // bits 2, 10, 31 open
  logic [31:0] evtIn = '0;
  logic [31:0] perReq = '0;
  logic [7:0]  chanStart = '0;
  logic [7:0]  faultClr = '0;
  logic [23:0] chanState;
  logic [31:0] evtPulse, ldAckPulse, stAckPulse;
  logic [7:0]  faultStatus, faultEvtErr, faultPerErr;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  // behavioural reference model
  int       mSt [8];
  int       mW  [8];
  bit [7:0] mFs, mEe, mPe;
  bit [31:0] mEvt, mLd, mSt2;
  int       nSt [8];
  int       nW  [8];
  bit [7:0] nFs, nEe, nPe;
  bit [31:0] nEvt, nLd, nSt2;

  always #2 clk = ~clk;

  dma_perm_guard u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind),
    .opIdx(opIdx), .opChan(opChan), .opNonSec(opNonSec),
    .evtNsMask(evtNsMask), .perNsMask(perNsMask), .evtIn(evtIn),
    .perReq(perReq), .chanStart(chanStart), .faultClr(faultClr),
    .chanState(chanState), .evtPulse(evtPulse), .ldAckPulse(ldAckPulse),
    .stAckPulse(stAckPulse), .faultStatus(faultStatus),
    .faultEvtErr(faultEvtErr), .faultPerErr(faultPerErr)
  );

  task automatic modelReset();
    for (int c = 0; c < 8; c++) begin mSt[c] = 0; mW[c] = 0; end
    mFs = '0; mEe = '0; mPe = '0; mEvt = '0; mLd = '0; mSt2 = '0;
  endtask

  task automatic modelStep();
    bit allow;
    for (int c = 0; c < 8; c++) begin nSt[c] = mSt[c]; nW[c] = mW[c]; end
    nFs = mFs; nEe = mEe; nPe = mPe; nEvt = '0; nLd = '0; nSt2 = '0;
    for (int c = 0; c < 8; c++) begin
      if (mSt[c] == 0 && chanStart[c]) nSt[c] = 1;
      if (mSt[c] == 2 && evtIn[mW[c]]) nSt[c] = 1;
      if (mSt[c] == 3 && perReq[mW[c]]) nSt[c] = 1;
      if (faultClr[c]) begin
        nFs[c] = 0; nEe[c] = 0; nPe[c] = 0;
        if (mSt[c] == 4) nSt[c] = 0;
      end
    end
    if (opValid && mSt[opChan] == 1 && opKind >= 1 && opKind <= 5) begin
      if (opKind <= 2) allow = !opNonSec || evtNsMask[opIdx];
      else             allow = !opNonSec || perNsMask[opIdx];
      if (allow) begin
        case (opKind)
          3'd1: begin nSt[opChan] = 2; nW[opChan] = opIdx; end
          3'd2: nEvt[opIdx] = 1;
          3'd3: begin nSt[opChan] = 3; nW[opChan] = opIdx; end
          3'd4: nLd[opIdx] = 1;
          default: nSt2[opIdx] = 1;
        endcase
      end else begin
        nSt[opChan] = 4;
        nFs[opChan] = 1;
        if (opKind <= 2) nEe[opChan] = 1; else nPe[opChan] = 1;
      end
    end
  endtask

  task automatic compare();
    logic [23:0] expSt;
    for (int c = 0; c < 8; c++) expSt[3*c +: 3] = 3'(mSt[c]);
    checks++;
    if (chanState !== expSt || evtPulse !== mEvt || ldAckPulse !== mLd ||
        stAckPulse !== mSt2 || faultStatus !== mFs || faultEvtErr !== mEe ||
        faultPerErr !== mPe) begin
      failures++;
      $display("FAIL %s: got st=%h ev=%h ld=%h sa=%h fs=%h ee=%h pe=%h exp st=%h ev=%h ld=%h sa=%h fs=%h ee=%h pe=%h",
               curReq, chanState, evtPulse, ldAckPulse, stAckPulse, faultStatus,
               faultEvtErr, faultPerErr, expSt, mEvt, mLd, mSt2, mFs, mEe, mPe);
    end
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    for (int c = 0; c < 8; c++) begin mSt[c] = nSt[c]; mW[c] = nW[c]; end
    mFs = nFs; mEe = nEe; mPe = nPe; mEvt = nEvt; mLd = nLd; mSt2 = nSt2;
    @(negedge clk);
    compare();
  endtask

  task automatic issue(input logic [2:0] k, input logic [2:0] ch,
                       input logic [4:0] idx, input logic ns);
    opValid = 1'b1; opKind = k; opChan = ch; opIdx = idx; opNonSec = ns;
    tick();
    opValid = 1'b0; opKind = 3'd0;
    tick();
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1"; compare();
    tick();

    curReq = "R2"; chanStart = 8'h0F; tick(); chanStart = '0; tick();

    // secure thread waits on event 5 despite closed mask
    curReq = "R9"; issue(3'd1, 3'd0, 5'd5, 1'b0);
    curReq = "R3"; evtIn = 32'h20; tick(); evtIn = '0; tick();

    // non-secure wait on open event 7, wrong event first
    curReq = "R3"; issue(3'd1, 3'd1, 5'd7, 1'b1);
    evtIn = 32'h40; tick(); evtIn = '0; tick();
    evtIn = 32'h80; tick(); evtIn = '0; tick();

    curReq = "R4"; issue(3'd2, 3'd2, 5'd9, 1'b1);
    curReq = "R5"; issue(3'd3, 3'd3, 5'd2, 1'b1);
    perReq = 32'h1; tick(); perReq = 32'h4; tick(); perReq = '0; tick();

    curReq = "R6"; issue(3'd4, 3'd0, 5'd10, 1'b1);
    issue(3'd5, 3'd0, 5'd31, 1'b1);
    curReq = "R9"; issue(3'd5, 3'd0, 5'd0, 1'b0);

    curReq = "R7"; issue(3'd2, 3'd1, 5'd0, 1'b1);
    curReq = "R11"; issue(3'd2, 3'd1, 5'd9, 1'b1);
    issue(3'd6, 3'd0, 5'd9, 1'b1);
    issue(3'd0, 3'd0, 5'd9, 1'b1);
    issue(3'd2, 3'd7, 5'd9, 1'b0);

    curReq = "R8"; issue(3'd4, 3'd2, 5'd4, 1'b1);
    issue(3'd3, 3'd3, 5'd4, 1'b1);
    curReq = "R7"; issue(3'd1, 3'd0, 5'd5, 1'b1);

    curReq = "R10"; repeat (3) tick();
    faultClr = 8'h02; tick(); faultClr = '0; tick();
    chanStart = 8'h02; tick(); chanStart = '0; tick();
    faultClr = 8'h0D; tick(); faultClr = '0; tick();
    curReq = "R2"; chanStart = 8'h05; tick(); chanStart = '0; tick();

    // new fault and clear in the same cycle on channel 2
    curReq = "R10";
    opValid = 1'b1; opKind = 3'd5; opChan = 3'd2; opIdx = 5'd4; opNonSec = 1'b1;
    faultClr = 8'h04; tick();
    opValid = 1'b0; opKind = 3'd0; faultClr = '0; tick();
    curReq = "R8"; issue(3'd5, 3'd0, 5'd0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule